// File: doc/BRIEF.md
# Open-Drain Byte Transmitter with Collision Abort

This block sends one byte at a time on a single shared data wire that an external resistor pulls high. The block never drives the wire high. It has only a pull-down enable: a logic 0 is sent by pulling the wire low, and a logic 1 is sent by letting go of it. Several nodes can therefore share the wire as a wired-AND without electrical conflict.

While it sends a 1, the block reads the wire back through a synchroniser. If the wire is still low at the middle of that bit, another node is holding it down. The block then stops at once, releases the wire and reports a collision. A frame is one low start bit, eight data bits with the least significant bit first, and one released stop bit. Each bit lasts `BIT_CYC` clock cycles.

A client puts a byte on `tx_byte` and pulses `tx_start` while `busy` is low. It then waits for a one-cycle pulse on either `tx_done` or `tx_collision`.

Top module: `od_byte_tx`

## Requirements
- R1: During reset and whenever the block is idle, `drive_low`, `busy`, `tx_done` and `tx_collision` are all 0.
- R2: A `tx_start` that is sampled high while idle latches `tx_byte` and begins a frame in the next cycle, which is frame cycle 0. The start bit holds `drive_low` at 1 for exactly `BIT_CYC` cycles.
- R3: Data bit k (k = 0 is the least significant bit) occupies frame cycles `BIT_CYC*(1+k)` to `BIT_CYC*(2+k)-1`. For a 0 bit `drive_low` is 1 over the whole period; for a 1 bit it is 0.
- R4: The stop bit keeps `drive_low` at 0 for `BIT_CYC` cycles. `tx_done` is then high for exactly one cycle, in frame cycle `10*BIT_CYC`, and `busy` falls in that same cycle.
- R5: During a 1 bit, the wire level from frame cycle `BIT_CYC*(1+k)+BIT_CYC/2` is judged once it has passed the synchroniser. If that level is low, the frame is abandoned. `tx_collision` is then high for one cycle in frame cycle `BIT_CYC*(1+k)+BIT_CYC/2+3`, and in that cycle `drive_low` and `busy` are both 0.
- R6: A low wire during a 0 bit is not a collision, and the frame goes on to complete with `tx_done`.
- R7: A `tx_start` pulse while `busy` is high is ignored. The byte being sent is not changed, and no second frame follows.
- R8: `tx_done` and `tx_collision` are never high together, and each is exactly one cycle wide.
- R9: `line_in` passes through a chain of `SYNC_STAGES` flip-flops (default 2) before it is used. The sample point is moved later by that many cycles, so the value judged is the wire level at the middle of the bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tx_byte | input | DATA_W | Byte to transmit, sampled together with `tx_start` |
| tx_start | input | 1 | Starts a frame when the block is idle |
| line_in | input | 1 | Level sensed on the shared wire (asynchronous) |
| drive_low | output | 1 | Enables the pull-down driver; 0 releases the wire |
| busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | One-cycle pulse after the stop bit has completed |
| tx_collision | output | 1 | One-cycle pulse when a 1 bit was found held low |

## Verification
Clean frames are sent with 0xA5, 0x00, 0xFF, 0x01 and 0x80. These patterns show whether the bit order is correct, whether the start and stop periods are placed correctly, and whether alternating, all-low and all-released bits are each formed properly. A second node is modelled by forcing the wire low over a single chosen bit. Forcing bit 0, 2 or 7 while that bit is a 1 checks the abort cycle and the release of the wire at the start, middle and end of the byte. Forcing a 0 bit shows that readback applies only to released bits. A start pulse in the middle of a frame checks that the byte being sent stays unchanged.

// File: rtl/od_tx_pkg.sv
package od_tx_pkg;

  // Frame phases of the transmitter
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;

  // Cycle within a bit at which the synchronised readback equals the mid-bit level
  function automatic int sample_offset(input int bit_cyc, input int sync_stages);
    return bit_cyc / 2 + sync_stages;
  endfunction

endpackage

// File: rtl/od_rst_sync.sv
module od_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  // Assertion is asynchronous, release walks through the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/od_line_sync.sv
module od_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RESET_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

  // R9: the output is the previous stage delayed by one cycle
  p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dout == $past(stg_q[STAGES-2])));

endmodule

// File: rtl/od_bit_timer.sv
module od_bit_timer #(
  parameter int BIT_CYC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_last,
  output logic sample_pt
);

  import od_tx_pkg::*;

  localparam int CW        = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int SAMPLE_AT = sample_offset(BIT_CYC, SYNC_STAGES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    if (!run)                          cnt_d = '0;
    else if (cnt_q == CW'(BIT_CYC-1))  cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = run || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bit_last  = run && (cnt_q == CW'(BIT_CYC-1));
  assign sample_pt = run && (cnt_q == CW'(SAMPLE_AT));

  // R2: the count stays inside one bit period
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BIT_CYC-1));

  // R2: the counter rests at zero while no frame runs
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/od_tx_seq.sv
module od_tx_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              line_s,
  input  logic              bit_last,
  input  logic              sample_pt,
  output logic              drive_low,
  output logic              busy,
  output logic              done,
  output logic              collision
);

  import od_tx_pkg::*;

  localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IW-1:0]     idx_q,   idx_d;
  logic              drive_q, drive_d;
  logic              done_q,  done_d;
  logic              coll_q,  coll_d;
  logic              clash;
  logic              shreg_en;

  // A released bit that still reads low at its checked point
  assign clash = (state_q == ST_DATA) && shreg_q[0] && sample_pt && !line_s;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    coll_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_START;
          shreg_d = data;
          idx_d   = '0;
        end
      end
      ST_START: begin
        if (bit_last) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (clash) begin
          state_d = ST_IDLE;
          coll_d  = 1'b1;
        end else if (bit_last) begin
          shreg_d = shreg_q >> 1;
          if (idx_q == IW'(DATA_W-1)) state_d = ST_STOP;
          else                        idx_d   = idx_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    drive_d = (state_d == ST_START) || ((state_d == ST_DATA) && !shreg_d[0]);
  end

  assign shreg_en = (state_q == ST_IDLE) ? start : bit_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= drive_d;
      done_q  <= done_d;
      coll_q  <= coll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      idx_q   <= '0;
    end else if (shreg_en) begin
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
    end
  end

  assign drive_low = drive_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign collision = coll_q;

  // R1: wire released when idle
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !drive_q);

  // R2: start bit is driven low
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> drive_q);

  // R3: data level follows the current bit
  p_zero_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && !shreg_q[0]) |-> drive_q);
  p_one_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && shreg_q[0]) |-> !drive_q);

  // R4: stop bit released, done only at its end
  p_stop_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> !drive_q);
  p_done_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == ST_STOP));

  // R5: abort leaves the wire released and the block idle
  p_abort_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_q |-> (!drive_q && (state_q == ST_IDLE)));

  // R6: a driven-low bit never raises a collision
  p_no_coll_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && !shreg_q[0]) |=> !coll_q);

  // R7: a start during data does not restart the frame
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && start) |=> (state_q != ST_START));

  // R8: results are exclusive single-cycle pulses
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && coll_q));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_coll_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_q |=> !coll_q);

endmodule

// File: rtl/od_byte_tx.sv
module od_byte_tx #(
  parameter int BIT_CYC     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_start,
  input  logic              line_in,
  output logic              drive_low,
  output logic              busy,
  output logic              tx_done,
  output logic              tx_collision
);

  logic rst_n_i;
  logic line_s;
  logic bit_last;
  logic sample_pt;
  logic busy_i;

  od_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  od_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (line_in),
    .dout  (line_s)
  );

  od_bit_timer #(.BIT_CYC(BIT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_bit_timer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .run       (busy_i),
    .bit_last  (bit_last),
    .sample_pt (sample_pt)
  );

  od_tx_seq #(.DATA_W(DATA_W)) u_tx_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (tx_start),
    .data      (tx_byte),
    .line_s    (line_s),
    .bit_last  (bit_last),
    .sample_pt (sample_pt),
    .drive_low (drive_low),
    .busy      (busy_i),
    .done      (tx_done),
    .collision (tx_collision)
  );

  assign busy = busy_i;

  // R1: outputs quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_i |-> (!drive_low && !tx_done && !tx_collision));

endmodule

// File: tb/od_byte_tx_bench.sv
`timescale 1ns/1ps
module od_byte_tx_bench;

  localparam int B = 16;
  localparam int H = B / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_start = 1'b0;
  logic       drive_low, busy, tx_done, tx_collision;
  logic       line;

  int jam_k = -1;
  int cyc = 0;
  bit active = 1'b0;
  logic [7:0] bits_seen = 8'h00;
  logic jam;

  int mon_checks = 0, mon_errs = 0;
  int drv_checks = 0, drv_errs = 0;
  bit finished = 1'b0;

  int exp_kind[$];
  int exp_cyc[$];
  int exp_byte[$];
  int exp_nbits[$];

  always #2.5 clk = ~clk;

  assign jam  = active && (jam_k >= 0) && (cyc >= B*(1+jam_k)) && (cyc < B*(2+jam_k));
  assign line = ~drive_low & ~jam;

  od_byte_tx u_od_byte_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_byte      (tx_byte),
    .tx_start     (tx_start),
    .line_in      (line),
    .drive_low    (drive_low),
    .busy         (busy),
    .tx_done      (tx_done),
    .tx_collision (tx_collision)
  );

  task automatic chk_m(input bit ok, input string req, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_d(input bit ok, input string req, input int act, input int exp);
    drv_checks++;
    if (!ok) begin
      drv_errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: rebuilds the frame from the wire and scores each result
  always @(negedge clk) begin
    if (!rst_n) begin
      active = 1'b0;
    end else begin
      if (!active && drive_low) begin
        active = 1'b1;
        cyc = 0;
        bits_seen = 8'h00;
      end else if (active) begin
        cyc++;
      end
      chk_m(!(tx_done && tx_collision), "R8 exclusive results", {tx_done, tx_collision}, 0);
      if (active) begin
        if (cyc == H) chk_m(line == 1'b0 && busy, "R2 start bit low", line, 0);
        for (int i = 0; i < 8; i++) begin
          if (cyc == B*(1+i) + H) bits_seen[i] = line;
        end
        if (cyc == 9*B + H) chk_m(!drive_low && line, "R4 stop bit released", drive_low, 0);
        if (tx_done || tx_collision) begin
          if (exp_kind.size() == 0) begin
            chk_m(1'b0, "R7 unexpected result", cyc, 0);
          end else begin
            int k, c, b, n, mask;
            k = exp_kind.pop_front();
            c = exp_cyc.pop_front();
            b = exp_byte.pop_front();
            n = exp_nbits.pop_front();
            mask = (1 << n) - 1;
            chk_m(int'(tx_collision) == k, k ? "R5 collision reported" : "R4 done reported",
                  int'(tx_collision), k);
            chk_m(cyc == c, k ? "R5 abort cycle" : "R4 done cycle", cyc, c);
            chk_m((int'(bits_seen) & mask) == (b & mask), "R3 bits on wire LSB first",
                  int'(bits_seen) & mask, b & mask);
            if (k == 1) chk_m(!drive_low && !busy, "R5 released after abort",
                              {drive_low, busy}, 0);
            else        chk_m(!busy, "R4 idle after done", busy, 0);
          end
          active = 1'b0;
        end
      end
    end
  end

  task automatic push_exp(input logic [7:0] b, input int jk);
    bit hit;
    hit = (jk >= 0) && b[jk];
    exp_kind.push_back(hit ? 1 : 0);
    exp_cyc.push_back(hit ? B*(1+jk) + H + 3 : 10*B);
    exp_byte.push_back(int'(b));
    exp_nbits.push_back(hit ? jk : 8);
  endtask

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk);
    tx_byte = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int jk);
    jam_k = jk;
    push_exp(b, jk);
    pulse_start(b);
    repeat (10*B + 12) @(negedge clk);
    chk_d(!busy && !drive_low, "R1 idle between frames", {busy, drive_low}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk_d(!drive_low && !busy && !tx_done && !tx_collision, "R1 reset state",
          {drive_low, busy, tx_done, tx_collision}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_d(!drive_low && !busy, "R1 idle after reset", {drive_low, busy}, 0);

    send(8'hA5, -1);   // R3 alternating pattern
    send(8'h00, -1);   // R3 all driven
    send(8'hFF, -1);   // R3 all released
    send(8'h01, -1);   // R3 LSB first
    send(8'h80, -1);   // R3 MSB last
    send(8'h04, 2);    // R5 collision mid-byte
    send(8'hFF, 0);    // R5 collision on first bit
    send(8'h80, 7);    // R5 collision on last bit
    send(8'hA5, 1);    // R6 low wire on a 0 bit, no collision

    // R7: start pulse in the middle of a frame
    jam_k = -1;
    push_exp(8'h3C, -1);
    pulse_start(8'h3C);
    repeat (40) @(negedge clk);
    pulse_start(8'hC3);
    repeat (10*B) @(negedge clk);
    chk_d(!busy && !drive_low, "R7 no second frame", {busy, drive_low}, 0);

    chk_d(exp_kind.size() == 0, "R8 every expected result seen", exp_kind.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors",
             mon_checks + drv_checks, mon_errs + drv_errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors",
               mon_checks + drv_checks + 1, mon_errs + drv_errs + 1);
      $finish;
    end
  end

endmodule